// File: doc/BRIEF.md
# High-Speed Downlink Subframe Timing Controller

This block derives the timing strobes for a high-speed downlink data path from a slot strobe and a radio-frame strobe. It keeps a slot position inside the frame. From that position it marks the start of every three-slot control subframe. It marks the matching data subframe two slots later. It marks a feedback start a programmable number of slots after each data subframe. Because several data subframes can be pending at once, a feedback start that overlaps later subframes is still produced for each one.

Alongside the strobes, the block reports the bit budget of one code for the modulation in force. This is given per slot and per subframe. It also checks a requested number of active data codes against a capability class, and reports the total bit budget of a subframe for that request. The modulation choice is captured when a control subframe begins and takes effect when the matching data subframe begins. A new choice therefore never changes a data subframe that has already started.

Top module: `hs_sf_timer`

## Requirements
- R1: The slot position runs 0 to 14 and wraps to 0. A slot strobe that comes with the frame strobe sets the position to 0. The frame strobe has no effect without a slot strobe.
- R2: `ctl_sf_start` is high for exactly one cycle. That cycle is the one right after a slot strobe that moves the position to 0, 3, 6, 9 or 12. It is low at all other times.
- R3: `data_sf_start` is high for exactly one cycle. That cycle is the one right after the second slot strobe following the slot strobe that raised `ctl_sf_start`.
- R4: `fb_start` is high for one cycle right after the slot strobe that comes `fb_delay` strobes (0 to 15) after a data-start strobe. The value used is `fb_delay` as it stands at that later strobe. With a delay of 0 it rises together with `data_sf_start`. Each pending data subframe gives its own feedback start, even when a later data subframe begins first.
- R5: `mod_sel` (0 = QPSK, 1 = 16QAM) is captured at the slot strobe that starts a control subframe. The budget outputs change to the captured value in the cycle when the matching `data_sf_start` is high, and at no other time.
- R6: For QPSK, `slot_bits` is 320 and `sf_bits` is 960. For 16QAM they are 640 and 1920. After reset the modulation is QPSK.
- R7: `codes_valid` is 1 exactly when 1 <= `code_req` <= limit. The limit is 5 for `cap_sel` 0, 10 for 1, and 15 for 2 or 3. The output appears one cycle after the inputs.
- R8: When the request is valid, `total_bits` equals `sf_bits` times `code_req`, and otherwise it is 0. It appears one cycle after `code_req`/`cap_sel`, using the modulation in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_stb | input | 1 | One-cycle pulse at each slot boundary |
| frame_stb | input | 1 | Marks the slot strobe that starts a radio frame |
| mod_sel | input | 1 | Modulation request: 0 QPSK, 1 16QAM |
| fb_delay | input | 4 | Slots from data start to feedback start |
| cap_sel | input | 2 | Capability class: 5, 10 or 15 codes |
| code_req | input | 4 | Requested number of active data codes |
| ctl_sf_start | output | 1 | Control subframe start pulse |
| data_sf_start | output | 1 | Data subframe start pulse |
| fb_start | output | 1 | Feedback start pulse |
| slot_bits | output | 11 | Bits per slot for one code |
| sf_bits | output | 11 | Bits per subframe for one code |
| total_bits | output | 15 | Subframe bits for all requested codes |
| codes_valid | output | 1 | Code request is within the capability limit |

## Verification
Every strobe output is registered once, so each one is due in the cycle right after the slot strobe that causes it. The bench raises the slot strobe for a single cycle on a falling edge and reads the three pulses on the next falling edge. It reads them again one cycle later to confirm that they have dropped. The budget outputs are compared in the same cycle as the data-start pulse that updates them. The code-count outputs are read one full cycle after `code_req` or `cap_sel` is driven, while no strobe is in flight. A bench model of slot position, control history, data history and captured modulation produces the expected value for each strobe.

// File: rtl/hs_sf_pkg.sv
package hs_sf_pkg;

   typedef enum logic [0:0] {
      MOD_QPSK  = 1'b0,
      MOD_QAM16 = 1'b1
   } mod_e;

   // code limit of a capability class: step, 2*step, ... capped at max
   function automatic int unsigned cap_limit(input logic [1:0] sel,
                                             input int unsigned step,
                                             input int unsigned max_codes);
      int unsigned lim;
      lim = (int'(sel) + 1) * step;
      if (lim > max_codes) lim = max_codes;
      return lim;
   endfunction

endpackage

// File: rtl/hs_sf_slot_seq.sv
module hs_sf_slot_seq #(
   parameter int SLOTS_PER_FRAME = 15,
   parameter int SLOTS_PER_SF    = 3,
   parameter int DATA_LAG        = 2,
   localparam int IDX_W          = $clog2(SLOTS_PER_FRAME)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_stb,
   input  logic              frame_stb,
   input  hs_sf_pkg::mod_e   mod_sel,
   output logic              ctl_start,
   output logic              data_start,
   output logic              data_evt,
   output hs_sf_pkg::mod_e   mod_act
);
   import hs_sf_pkg::*;

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS_PER_FRAME - 1);

   if (SLOTS_PER_FRAME % SLOTS_PER_SF != 0) begin : g_bad_frame
      $error("frame length must be a whole number of subframes");
   end
   if (DATA_LAG < 1) begin : g_bad_lag
      $error("data lag must be at least one slot");
   end

   logic [IDX_W-1:0] idx_q, idx_n;
   logic             ctl_evt;
   logic [DATA_LAG-1:0] pend_q;
   mod_e             mpipe_q [DATA_LAG];

   always_comb begin
      if (frame_stb || idx_q == LAST_IDX) idx_n = '0;
      else                                 idx_n = idx_q + 1'b1;
      ctl_evt  = slot_stb && ((int'(idx_n) % SLOTS_PER_SF) == 0);
      data_evt = slot_stb && pend_q[DATA_LAG-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q      <= LAST_IDX;
         pend_q     <= '0;
         ctl_start  <= 1'b0;
         data_start <= 1'b0;
         mod_act    <= MOD_QPSK;
         for (int i = 0; i < DATA_LAG; i++) mpipe_q[i] <= MOD_QPSK;
      end else begin
         ctl_start  <= ctl_evt;
         data_start <= data_evt;
         if (slot_stb) begin
            idx_q <= idx_n;
            for (int i = DATA_LAG - 1; i > 0; i--) begin
               pend_q[i]  <= pend_q[i-1];
               mpipe_q[i] <= mpipe_q[i-1];
            end
            pend_q[0]  <= ctl_evt;
            mpipe_q[0] <= mod_sel;
         end
         if (data_evt) mod_act <= mpipe_q[DATA_LAG-1];
      end
   end

   AST_SLOT_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(idx_q) < SLOTS_PER_FRAME);  // R1

   AST_CTL_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_start |-> $past(slot_stb));  // R2

   AST_DATA_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      data_start |-> $past(slot_stb));  // R3

endmodule

// File: rtl/hs_sf_fb_delay.sv
module hs_sf_fb_delay #(
   parameter int FB_MAX  = 15,
   localparam int DLY_W  = (FB_MAX < 1) ? 1 : $clog2(FB_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot_stb,
   input  logic             data_evt,
   input  logic [DLY_W-1:0] fb_delay,
   output logic             fb_start
);

   if (FB_MAX < 0) begin : g_bad_max
      $error("feedback delay range must not be negative");
   end

   if (FB_MAX == 0) begin : g_fixed
      always_ff @(posedge clk) begin
         if (!rst_n) fb_start <= 1'b0;
         else        fb_start <= data_evt;
      end
   end else begin : g_shift
      logic [FB_MAX-1:0] hist_q;
      logic              tap;

      always_comb begin
         if (fb_delay == '0)                tap = data_evt;
         else if (int'(fb_delay) > FB_MAX)  tap = slot_stb && hist_q[FB_MAX-1];
         else                               tap = slot_stb && hist_q[int'(fb_delay) - 1];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hist_q   <= '0;
            fb_start <= 1'b0;
         end else begin
            fb_start <= tap;
            if (slot_stb) begin
               if (FB_MAX > 1) hist_q <= {hist_q[FB_MAX-2:0], data_evt};
               else            hist_q <= data_evt;
            end
         end
      end
   end

endmodule

// File: rtl/hs_sf_budget.sv
module hs_sf_budget #(
   parameter int BASE_BITS    = 320,
   parameter int SLOTS_PER_SF = 3,
   parameter int MAX_CODES    = 15,
   parameter int CAP_STEP     = 5,
   localparam int CODE_W      = $clog2(MAX_CODES + 1),
   localparam int BITS_W      = $clog2(2 * BASE_BITS * SLOTS_PER_SF + 1),
   localparam int TOT_W       = $clog2(2 * BASE_BITS * SLOTS_PER_SF * MAX_CODES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  hs_sf_pkg::mod_e   mod_act,
   input  logic [1:0]        cap_sel,
   input  logic [CODE_W-1:0] code_req,
   output logic [BITS_W-1:0] slot_bits,
   output logic [BITS_W-1:0] sf_bits,
   output logic [TOT_W-1:0]  total_bits,
   output logic              codes_valid
);
   import hs_sf_pkg::*;

   if (CAP_STEP < 1 || MAX_CODES < CAP_STEP) begin : g_bad_caps
      $error("capability step must be between 1 and the code maximum");
   end

   logic        valid_n;
   int unsigned limit;

   always_comb begin
      slot_bits = (mod_act == MOD_QAM16) ? BITS_W'(2 * BASE_BITS) : BITS_W'(BASE_BITS);
      sf_bits   = BITS_W'(int'(slot_bits) * SLOTS_PER_SF);
      limit     = cap_limit(cap_sel, CAP_STEP, MAX_CODES);
      valid_n   = (code_req != '0) && (int'(code_req) <= int'(limit));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         codes_valid <= 1'b0;
         total_bits  <= '0;
      end else begin
         codes_valid <= valid_n;
         total_bits  <= valid_n ? TOT_W'(int'(sf_bits) * int'(code_req)) : '0;
      end
   end

   AST_TOTAL_ZERO_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      !codes_valid |-> total_bits == '0);  // R8

endmodule

// File: rtl/hs_sf_timer.sv
module hs_sf_timer #(
   parameter int SLOTS_PER_FRAME = 15,
   parameter int SLOTS_PER_SF    = 3,
   parameter int DATA_LAG        = 2,
   parameter int FB_MAX          = 15,
   parameter int BASE_BITS       = 320,
   parameter int MAX_CODES       = 15,
   parameter int CAP_STEP        = 5,
   localparam int DLY_W          = (FB_MAX < 1) ? 1 : $clog2(FB_MAX + 1),
   localparam int CODE_W         = $clog2(MAX_CODES + 1),
   localparam int BITS_W         = $clog2(2 * BASE_BITS * SLOTS_PER_SF + 1),
   localparam int TOT_W          = $clog2(2 * BASE_BITS * SLOTS_PER_SF * MAX_CODES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_stb,
   input  logic              frame_stb,
   input  logic              mod_sel,
   input  logic [DLY_W-1:0]  fb_delay,
   input  logic [1:0]        cap_sel,
   input  logic [CODE_W-1:0] code_req,
   output logic              ctl_sf_start,
   output logic              data_sf_start,
   output logic              fb_start,
   output logic [BITS_W-1:0] slot_bits,
   output logic [BITS_W-1:0] sf_bits,
   output logic [TOT_W-1:0]  total_bits,
   output logic              codes_valid
);
   import hs_sf_pkg::*;

   logic data_evt;
   mod_e mod_act;

   hs_sf_slot_seq #(
      .SLOTS_PER_FRAME (SLOTS_PER_FRAME),
      .SLOTS_PER_SF    (SLOTS_PER_SF),
      .DATA_LAG        (DATA_LAG)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_stb   (slot_stb),
      .frame_stb  (frame_stb),
      .mod_sel    (mod_e'(mod_sel)),
      .ctl_start  (ctl_sf_start),
      .data_start (data_sf_start),
      .data_evt   (data_evt),
      .mod_act    (mod_act)
   );

   hs_sf_fb_delay #(
      .FB_MAX (FB_MAX)
   ) u_fb (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot_stb (slot_stb),
      .data_evt (data_evt),
      .fb_delay (fb_delay),
      .fb_start (fb_start)
   );

   hs_sf_budget #(
      .BASE_BITS    (BASE_BITS),
      .SLOTS_PER_SF (SLOTS_PER_SF),
      .MAX_CODES    (MAX_CODES),
      .CAP_STEP     (CAP_STEP)
   ) u_budget (
      .clk         (clk),
      .rst_n       (rst_n),
      .mod_act     (mod_act),
      .cap_sel     (cap_sel),
      .code_req    (code_req),
      .slot_bits   (slot_bits),
      .sf_bits     (sf_bits),
      .total_bits  (total_bits),
      .codes_valid (codes_valid)
   );

   AST_FB_ZERO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (data_sf_start && $past(fb_delay) == '0) |-> fb_start);  // R4

   AST_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !data_sf_start |-> $stable(slot_bits));  // R5

endmodule

// File: tb/hs_sf_timer_bench.sv
module hs_sf_timer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slot_stb = 1'b0;
   logic        frame_stb = 1'b0;
   logic        mod_sel = 1'b0;
   logic [3:0]  fb_delay = '0;
   logic [1:0]  cap_sel = '0;
   logic [3:0]  code_req = '0;
   logic        ctl_sf_start, data_sf_start, fb_start, codes_valid;
   logic [10:0] slot_bits, sf_bits;
   logic [14:0] total_bits;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model
   int        m_idx;
   logic [15:0] ctl_h, data_h, mod_h;
   int        m_mod;
   int        nstb;

   always #5ns clk = ~clk;

   hs_sf_timer u_hs_sf_timer (
      .clk           (clk),
      .rst_n         (rst_n),
      .slot_stb      (slot_stb),
      .frame_stb     (frame_stb),
      .mod_sel       (mod_sel),
      .fb_delay      (fb_delay),
      .cap_sel       (cap_sel),
      .code_req      (code_req),
      .ctl_sf_start  (ctl_sf_start),
      .data_sf_start (data_sf_start),
      .fb_start      (fb_start),
      .slot_bits     (slot_bits),
      .sf_bits       (sf_bits),
      .total_bits    (total_bits),
      .codes_valid   (codes_valid)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: %s got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // one slot strobe, model update and pulse checks
   task automatic strobe(input bit frame);
      bit e_ctl, e_data, e_fb;
      @(negedge clk);
      slot_stb  = 1'b1;
      frame_stb = frame;
      @(negedge clk);
      slot_stb  = 1'b0;
      frame_stb = 1'b0;
      m_idx  = (frame || m_idx == 14) ? 0 : m_idx + 1;   // R1
      e_ctl  = (m_idx % 3) == 0;
      e_data = ctl_h[1];
      e_fb   = (fb_delay == 0) ? e_data : data_h[fb_delay - 1];
      if (e_data) m_mod = mod_h[1];
      ctl_h  = {ctl_h[14:0], e_ctl};
      data_h = {data_h[14:0], e_data};
      mod_h  = {mod_h[14:0], mod_sel};
      chk("R2", "ctl_sf_start", ctl_sf_start, e_ctl);
      chk("R3", "data_sf_start", data_sf_start, e_data);
      chk("R4", "fb_start", fb_start, e_fb);
      chk("R6", "slot_bits", slot_bits, m_mod ? 640 : 320);
      chk("R5", "sf_bits", sf_bits, m_mod ? 1920 : 960);
      @(negedge clk);
      chk("R2", "ctl pulse width", ctl_sf_start, 0);
      chk("R3", "data pulse width", data_sf_start, 0);
      chk("R4", "fb pulse width", fb_start, 0);
      nstb++;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_idx = 14; ctl_h = '0; data_h = '0; mod_h = '0; m_mod = 0; nstb = 0;
      @(negedge clk);
      chk("R2", "reset ctl", ctl_sf_start, 0);
      chk("R3", "reset data", data_sf_start, 0);
      chk("R4", "reset fb", fb_start, 0);
      chk("R6", "reset slot_bits", slot_bits, 320);
      chk("R6", "reset sf_bits", sf_bits, 960);
      chk("R7", "reset codes_valid", codes_valid, 0);
      chk("R8", "reset total", total_bits, 0);
   endtask

   // run a frame-aligned sequence with a modulation pattern
   task automatic t_frames(input int dly, input int n, input int mod_mode);
      fb_delay = 4'(dly);
      for (int i = 0; i < n; i++) begin
         case (mod_mode)
            0: mod_sel = 1'b0;
            1: mod_sel = 1'b1;
            default: mod_sel = 1'((nstb / 3) % 2);
         endcase
         strobe(i == 0);
      end
   endtask

   // a frame strobe in the middle of a frame realigns the subframes (R1)
   task automatic t_realign();
      for (int i = 0; i < 7; i++) strobe(0);
      mod_sel = 1'b1;
      strobe(1);
      chk("R1", "realigned position", m_idx, 0);
      for (int i = 0; i < 8; i++) begin
         mod_sel = 1'(i % 2);
         strobe(0);
      end
   endtask

   // frame strobe alone has no effect (R1)
   task automatic t_frame_alone();
      @(negedge clk);
      frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
      chk("R1", "lone frame ctl", ctl_sf_start, 0);
      chk("R1", "lone frame data", data_sf_start, 0);
      strobe(0);
   endtask

   task automatic codes_case(input int cap, input int req);
      int lim;
      int ev;
      cap_sel  = 2'(cap);
      code_req = 4'(req);
      @(negedge clk);
      lim = (cap == 0) ? 5 : (cap == 1) ? 10 : 15;
      ev  = (req >= 1 && req <= lim) ? 1 : 0;
      chk("R7", $sformatf("codes_valid cap=%0d req=%0d", cap, req), codes_valid, ev);
      chk("R8", $sformatf("total cap=%0d req=%0d", cap, req), total_bits,
          ev ? (m_mod ? 1920 : 960) * req : 0);
   endtask

   task automatic t_codes();
      codes_case(0, 0);
      codes_case(0, 1);
      codes_case(0, 5);
      codes_case(0, 6);
      codes_case(1, 10);
      codes_case(1, 11);
      codes_case(2, 15);
      codes_case(3, 15);
      codes_case(3, 7);
   endtask

   initial begin
      t_reset();
      t_codes();
      t_frames(0, 20, 2);
      t_codes();
      t_frames(5, 20, 1);
      t_codes();
      t_frames(15, 34, 2);
      t_frames(2, 6, 0);
      t_realign();
      t_frame_alone();
      t_codes();
      repeat (3) @(negedge clk);
      finish_run();
   end

   initial begin
      #1ms;
      errors++;
      $display("FAIL watchdog: run did not complete, got 1 expected 0");
      finish_run();
   end

endmodule